// File: doc/BRIEF.md
# Register-Mapped Serial Host Port

This block is a byte-wide synchronous serial port that works as the clock-generating host. Software reaches it through three registers on a small parallel bus. The registers are control at address 0, status at address 1 and data at address 2. Reads return data in the same cycle, from combinational logic. A read or write takes effect on the clock edge that samples `bus_rd` or `bus_wr`.

Software first writes the control register. This picks one of four serial clock rates, the clock polarity and the clock phase, and sets the host and run bits. A write to the data register then loads the shift register and starts a transfer. During the transfer the byte leaves on `mosi_o` most significant bit first, and `miso_i` is sampled at the same time.

After the last serial clock edge, the received byte is held in a read buffer and a done flag is raised. If interrupts are enabled, an interrupt request is raised as well. Software clears the flag in two steps, a status read and then a data read. A data write made while the flag is set is dropped until software has read the status. The input `sel_guard` must stay high for host operation. When it falls, the host and run bits drop and any transfer in progress is abandoned.

Top module: `spi_host_port`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, `sck_o` is low and `irq_o` is low.
- R2: Control bits [1:0] set the serial clock period to 4, 8, 16 or 32 system clocks for codes 0, 1, 2 and 3. Each clock level lasts half that period.
- R3: Whenever no transfer is active, `sck_o` rests at the level of control bit 3 (polarity).
- R4: Control bit 2 (phase) sets the timing. With phase 0, `mosi_o` shows bit 7 before the first edge, the line is sampled on leading edges and it changes on trailing edges. With phase 1, it changes on leading edges and is sampled on trailing edges. In both cases the bits leave most significant first.
- R5: When a transfer completes, the byte sampled from `miso_i` (first sample in bit 7) goes to a buffer, and reads of address 2 return it.
- R6: Status bit 7 (done) rises together with the final serial clock edge of a transfer. `irq_o` is high exactly while done is set and control bit 7 (interrupt enable) is 1.
- R7: The done flag clears only on a data read that follows a status read made while done was set. A data read with no such status read leaves done set.
- R8: A data write made while done is set and status has not been read since is discarded. No transfer starts and the read buffer keeps its value.
- R9: While `sel_guard` is low, control bits 4 (host) and 6 (run) are forced to 0 and any active transfer is dropped. A drop sampled in the cycle of the final edge prevents completion.
- R10: A data write is ignored while a transfer is active, and also while host or run is 0.
- R11: A transfer started after the status read, with done still set, cancels that status read. A data read after this transfer therefore leaves done set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (drives the status-read and data-read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| sel_guard | input | 1 | Must be high for host operation |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Transfer-complete interrupt request |

## Verification
Two events can fall in the same cycle: the final serial clock edge that completes a transfer, and `sel_guard` falling. The bench counts system clocks from the cycle that accepts the data write, so that the guard drop is sampled either exactly on the final edge or one cycle after it. In the first case the status register must still read 0x00, with the clock at rest. In the second case it must read 0x80. A bus-facing serial model drives `miso_i`, collects `mosi_o` and times every serial edge against the scoreboard entry of the current transfer.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  // Register addresses on the parallel bus
  typedef enum logic [1:0] {
    RG_CTL  = 2'd0,
    RG_STAT = 2'd1,
    RG_DATA = 2'd2,
    RG_NONE = 2'd3
  } reg_sel_e;

  // Control register layout, bit 7 down to bit 0
  typedef struct packed {
    logic       irq_en;  // 7
    logic       run_en;  // 6
    logic       spare;   // 5, reads 0
    logic       host;    // 4
    logic       pol;     // 3
    logic       pha;     // 2
    logic [1:0] rate;    // 1:0
  } ctl_t;

  localparam int STAT_DONE_BIT = 7;

  // System clocks per serial clock level for a rate code
  function automatic int unsigned half_period(input logic [1:0] rate);
    return 32'd2 << rate;
  endfunction

  // An edge samples when its index parity equals the phase bit
  function automatic logic is_sample_edge(input logic pha, input logic idx_lsb);
    return idx_lsb == pha;
  endfunction

endpackage

// File: rtl/spi_host_sclk.sv
module spi_host_sclk
  import spi_host_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int EDGES = 2 * DATA_W,
  localparam int EDGE_W = $clog2(EDGES),
  localparam int CNT_W = $clog2(half_period(2'b11))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [1:0]        rate,
  input  logic              pol,
  output logic              busy,
  output logic              edge_fire,
  output logic              last_edge,
  output logic [EDGE_W-1:0] edge_idx,
  output logic              sck
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;
  logic             lvl_q;

  assign half_m1   = CNT_W'(half_period(rate) - 1);
  assign edge_fire = busy && (cnt_q >= half_m1);
  assign last_edge = edge_fire && (edge_idx == EDGE_W'(EDGES - 1));
  assign sck       = lvl_q ^ pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt_q    <= '0;
      edge_idx <= '0;
      lvl_q    <= 1'b0;
    end else if (abort) begin
      busy     <= 1'b0;
      cnt_q    <= '0;
      edge_idx <= '0;
      lvl_q    <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      cnt_q    <= '0;
      edge_idx <= '0;
      lvl_q    <= 1'b0;
    end else if (busy) begin
      if (edge_fire) begin
        cnt_q    <= '0;
        edge_idx <= edge_idx + 1'b1;
        lvl_q    <= ~lvl_q;
        if (last_edge) busy <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
  import spi_host_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int EDGE_W = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              edge_fire,
  input  logic              last_edge,
  input  logic [EDGE_W-1:0] edge_idx,
  input  logic              pha,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);

  logic [DATA_W-1:0] shreg_q;
  logic              samp_q;
  logic              sample_edge;
  logic              shift_edge;

  assign sample_edge = edge_fire && is_sample_edge(pha, edge_idx[0]);
  assign shift_edge  = edge_fire && !last_edge && !is_sample_edge(pha, edge_idx[0])
                       && (edge_idx != '0);
  assign mosi        = shreg_q[DATA_W-1];
  // Phase 1 takes its final sample on the completing edge itself
  assign rx_word     = {shreg_q[DATA_W-2:0], (pha ? miso : samp_q)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      samp_q  <= 1'b0;
    end else if (load) begin
      shreg_q <= load_data;
    end else begin
      if (sample_edge) samp_q <= miso;
      if (shift_edge) shreg_q <= {shreg_q[DATA_W-2:0], samp_q};
    end
  end

endmodule

// File: rtl/spi_host_flags.sv
module spi_host_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_done,
  input  logic start,
  input  logic stat_rd,
  input  logic data_rd,
  output logic done,
  output logic seen,
  output logic wr_lock
);

  logic clear_hit;

  assign clear_hit = data_rd && seen;
  assign wr_lock   = done && !seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      seen <= 1'b0;
    end else begin
      if (set_done)       done <= 1'b1;
      else if (clear_hit) done <= 1'b0;

      if (start || set_done || clear_hit) seen <= 1'b0;
      else if (stat_rd && done)           seen <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_host_port.sv
module spi_host_port
  import spi_host_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int EDGE_W = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sel_guard,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              irq_o
);

  reg_sel_e          sel;
  ctl_t              ctl_q;
  logic [DATA_W-1:0] rx_buf_q;
  logic [DATA_W-1:0] rx_word;
  logic [EDGE_W-1:0] edge_idx;

  // Named internal events
  logic wr_ctl, wr_data, rd_stat, rd_data;
  logic busy, edge_fire, last_edge;
  logic start_xfer, abort_xfer, fin_ok;
  logic st_done, st_seen, wr_lock;
  logic ctl_pol, ctl_host, ctl_run;
  logic [1:0] ctl_rate;

  assign sel     = reg_sel_e'(bus_addr);
  assign wr_ctl  = bus_wr && (sel == RG_CTL);
  assign wr_data = bus_wr && (sel == RG_DATA);
  assign rd_stat = bus_rd && (sel == RG_STAT);
  assign rd_data = bus_rd && (sel == RG_DATA);

  assign ctl_pol  = ctl_q.pol;
  assign ctl_host = ctl_q.host;
  assign ctl_run  = ctl_q.run_en;
  assign ctl_rate = ctl_q.rate;

  assign start_xfer = wr_data && ctl_host && ctl_run && sel_guard && !busy && !wr_lock;
  assign abort_xfer = !sel_guard;
  assign fin_ok     = last_edge && sel_guard;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      if (wr_ctl) begin
        ctl_q       <= ctl_t'(bus_wdata[7:0]);
        ctl_q.spare <= 1'b0;
      end
      if (!sel_guard) begin
        ctl_q.host   <= 1'b0;
        ctl_q.run_en <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_buf_q <= '0;
    else if (fin_ok) rx_buf_q <= rx_word;
  end

  spi_host_sclk #(.DATA_W(DATA_W)) u_sclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_xfer),
    .abort     (abort_xfer),
    .rate      (ctl_rate),
    .pol       (ctl_pol),
    .busy      (busy),
    .edge_fire (edge_fire),
    .last_edge (last_edge),
    .edge_idx  (edge_idx),
    .sck       (sck_o)
  );

  spi_host_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_xfer),
    .load_data (bus_wdata),
    .edge_fire (edge_fire),
    .last_edge (last_edge),
    .edge_idx  (edge_idx),
    .pha       (ctl_q.pha),
    .miso      (miso_i),
    .mosi      (mosi_o),
    .rx_word   (rx_word)
  );

  spi_host_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_done (fin_ok),
    .start    (start_xfer),
    .stat_rd  (rd_stat),
    .data_rd  (rd_data),
    .done     (st_done),
    .seen     (st_seen),
    .wr_lock  (wr_lock)
  );

  always_comb begin
    case (sel)
      RG_CTL:  bus_rdata = DATA_W'(ctl_q);
      RG_STAT: bus_rdata = DATA_W'(st_done) << STAT_DONE_BIT;
      RG_DATA: bus_rdata = rx_buf_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o = st_done && ctl_q.irq_en;

endmodule

// File: rtl/spi_host_port_chk.sv
module spi_host_port_chk
  import spi_host_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       edge_fire,
  input logic       fin,
  input logic       sck,
  input logic       pol,
  input logic [1:0] rate,
  input logic       done,
  input logic       seen,
  input logic       wr_data,
  input logic       rd_data,
  input logic       guard,
  input logic       host,
  input logic       run_en
);

  logic [4:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gap_q <= '0;
    else if (!busy || edge_fire) gap_q <= '0;
    else                        gap_q <= gap_q + 1'b1;
  end

  // R2: spacing between serial edges follows the rate code
  p_edge_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_fire |-> gap_q == 5'(half_period(rate) - 1));

  // R3: clock rests at polarity while idle
  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == pol);

  // R6: done only rises from a completed transfer
  p_done_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fin));

  // R7: lone data read keeps the flag
  p_keep_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && done && !seen && !fin) |=> done);

  // R8: locked data write starts nothing
  p_lockout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && done && !seen && !busy) |=> !busy);

  // R9: guard low drops host, run and any transfer
  p_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !guard |=> (!host && !run_en && !busy));

endmodule

bind spi_host_port spi_host_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .edge_fire (edge_fire),
  .fin       (fin_ok),
  .sck       (sck_o),
  .pol       (ctl_pol),
  .rate      (ctl_rate),
  .done      (st_done),
  .seen      (st_seen),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .guard     (sel_guard),
  .host      (ctl_host),
  .run_en    (ctl_run)
);

// File: tb/spi_host_port_test.sv
module spi_host_port_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  wire  [7:0] bus_rdata;
  logic       sel_guard = 1'b1;
  wire        sck_o;
  wire        mosi_o;
  logic       miso_i = 1'b0;
  wire        irq_o;

  always #2 clk = ~clk;

  spi_host_port uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sel_guard (sel_guard),
    .sck_o     (sck_o),
    .mosi_o    (mosi_o),
    .miso_i    (miso_i),
    .irq_o     (irq_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] tx;
    int         half;
    logic       pha;
  } exp_t;

  exp_t       sb_q[$];
  exp_t       cur;
  logic       arm = 1'b0;
  logic       active = 1'b0;
  logic [7:0] slv = 8'h00;
  logic [7:0] got = 8'h00;
  logic       prev_sck = 1'b0;
  int         idle_toggles = 0;
  int         ecnt = 0;
  int         gap = 0;
  int         shifts = 0;
  int         bad_gap = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor and serial peer: drives miso, collects mosi, times edges
  always @(negedge clk) begin
    gap++;
    if (arm && sb_q.size() > 0) begin
      cur = sb_q[0];
      active = 1'b1;
      arm = 1'b0;
      ecnt = 0; shifts = 0; got = 8'h00; bad_gap = 0; gap = 0;
      miso_i = slv[7];
    end
    if (sck_o !== prev_sck) begin
      if (!active) begin
        idle_toggles++;
      end else begin
        if (ecnt > 0 && gap != cur.half) bad_gap = 1;
        if ((ecnt % 2) == int'(cur.pha)) begin
          got = {got[6:0], mosi_o};
        end else if (ecnt != 0 && ecnt != 15) begin
          shifts++;
          miso_i = slv[7 - shifts];
        end
        ecnt++;
        if (ecnt == 16) begin
          void'(sb_q.pop_front());
          chk("R4 mosi bit stream", got, cur.tx);
          chk("R2 sck level duration", bad_gap, 0);
          active = 1'b0;
        end
      end
      gap = 0;
    end
    prev_sck = sck_o;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Driver: pushes the expected item, arms the peer, starts a transfer
  task automatic xfer_begin(input logic [7:0] ctl, input logic [7:0] tx, input logic [7:0] s);
    exp_t e;
    e.tx = tx; e.half = 2 << ctl[1:0]; e.pha = ctl[2];
    wr(2'd0, ctl);
    @(negedge clk);
    sb_q.push_back(e);
    slv = s;
    arm = 1'b1;
    @(negedge clk);
    wr(2'd2, tx);
  endtask

  task automatic xfer(input logic [7:0] ctl, input logic [7:0] tx, input logic [7:0] s);
    xfer_begin(ctl, tx, s);
    repeat (16 * (2 << ctl[1:0]) + 4) @(negedge clk);
  endtask

  function automatic logic [7:0] mk(input logic ie, input logic pol, input logic pha,
                                     input logic [1:0] rate);
    return {ie, 1'b1, 1'b0, 1'b1, pol, pha, rate};
  endfunction

  task automatic mode_run(input logic [7:0] ctl, input logic [7:0] tx, input logic [7:0] s);
    logic [7:0] d;
    xfer(ctl, tx, s);
    chk("R3 idle level after transfer", sck_o, ctl[3]);
    chk("R6 irq with flag set", irq_o, ctl[7]);
    rd(2'd1, d); chk("R6 done flag set", d, 8'h80);
    rd(2'd2, d); chk("R5 received byte", d, s);
    rd(2'd1, d); chk("R7 flag cleared by status then data read", d, 8'h00);
    chk("R6 irq cleared", irq_o, 1'b0);
  endtask

  initial begin
    logic [7:0] d;
    int tog0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 control after reset", d, 8'h00);
    rd(2'd1, d); chk("R1 status after reset", d, 8'h00);
    chk("R1 sck after reset", sck_o, 1'b0);
    chk("R1 irq after reset", irq_o, 1'b0);

    // R2 R3 R4 R5 R6: four timing modes at four rates
    mode_run(mk(1'b1, 1'b0, 1'b0, 2'd0), 8'hA5, 8'h3C);
    mode_run(mk(1'b0, 1'b0, 1'b1, 2'd1), 8'h96, 8'hC3);
    mode_run(mk(1'b1, 1'b1, 1'b0, 2'd2), 8'h01, 8'h80);
    mode_run(mk(1'b0, 1'b1, 1'b1, 2'd3), 8'hFF, 8'h5A);

    // R8 lockout and R7 lone data read
    xfer(mk(1'b0, 1'b0, 1'b0, 2'd0), 8'h5C, 8'h2B);
    tog0 = idle_toggles;
    wr(2'd2, 8'h77);
    repeat (40) @(negedge clk);
    chk("R8 locked write starts no clock", idle_toggles, tog0);
    rd(2'd2, d); chk("R8 buffer kept after locked write", d, 8'h2B);
    rd(2'd1, d); chk("R7 flag kept after lone data read", d, 8'h80);
    rd(2'd2, d);
    rd(2'd1, d); chk("R7 flag cleared", d, 8'h00);

    // R11 new transfer after status read cancels it
    xfer(mk(1'b0, 1'b0, 1'b0, 2'd0), 8'hC6, 8'h39);
    rd(2'd1, d);
    xfer(mk(1'b0, 1'b0, 1'b0, 2'd0), 8'h4D, 8'hE2);
    rd(2'd2, d); chk("R11 buffer holds second byte", d, 8'hE2);
    rd(2'd1, d); chk("R11 flag kept after restart", d, 8'h80);
    rd(2'd2, d);
    rd(2'd1, d); chk("R11 flag cleared after fresh status read", d, 8'h00);

    // R10 write while active is ignored
    xfer_begin(mk(1'b0, 1'b0, 1'b0, 2'd1), 8'hB4, 8'h6E);
    repeat (20) @(negedge clk);
    wr(2'd2, 8'h0F);
    repeat (16 * 4 + 4) @(negedge clk);
    rd(2'd1, d);
    rd(2'd2, d); chk("R10 buffer from first transfer", d, 8'h6E);

    // R10 write with run bit clear is ignored
    wr(2'd0, 8'h10);
    @(negedge clk);
    tog0 = idle_toggles;
    wr(2'd2, 8'h55);
    repeat (40) @(negedge clk);
    chk("R10 no clock without run bit", idle_toggles, tog0);
    rd(2'd1, d); chk("R10 no completion without run bit", d, 8'h00);

    // R9 guard drop clears host and run
    wr(2'd0, 8'hD5);
    sel_guard = 1'b0;
    @(negedge clk);
    sel_guard = 1'b1;
    rd(2'd0, d); chk("R9 host and run cleared", d, 8'h85);

    // R9 guard drop sampled on the final edge: no completion
    wr(2'd0, 8'h50);
    @(negedge clk);
    wr(2'd2, 8'h99);
    repeat (31) @(negedge clk);
    sel_guard = 1'b0;
    @(negedge clk);
    sel_guard = 1'b1;
    rd(2'd1, d); chk("R9 drop on final edge blocks completion", d, 8'h00);
    chk("R9 clock at rest after drop", sck_o, 1'b0);
    rd(2'd0, d); chk("R9 control after drop", d, 8'h00);

    // R9 guard drop one cycle after the final edge: completion stands
    wr(2'd0, 8'h50);
    @(negedge clk);
    wr(2'd2, 8'h99);
    repeat (32) @(negedge clk);
    sel_guard = 1'b0;
    @(negedge clk);
    sel_guard = 1'b1;
    rd(2'd1, d); chk("R9 drop after final edge keeps completion", d, 8'h80);
    rd(2'd2, d);

    chk("R4 scoreboard drained", sb_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule